// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block runs on the host side of a parallel NOR flash. It decides when an embedded program or erase operation inside the flash has finished. After software has issued the operation, a single `start` pulse hands control to the poller. The poller then reads the flash's 8-bit status byte over a simple request/acknowledge read port. It compares the toggle bit (bit 6) across back-to-back reads and consults the timing-limit flag (bit 5) whenever the toggle bit is still moving.

The block ends in one of two ways. It can report a clean completion. Otherwise, on any failure path, it writes a configurable reset command byte to the flash so that the device returns to array read mode, and only then reports failure. A host-side watchdog bounds the number of read pairs in case the flash never settles and never raises its timing-limit flag.

Top module: `flash_toggle_poller`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `busy`, `done`, `ok`, `fail`, `rd_req` and `wr_req` all low.
- R2: A `start` accepted while idle raises `busy` and `rd_req` on the following cycle. A read completes only in a cycle with `rd_req` and `rd_ack` both high, and `rd_req` stays high until that happens. Each poll pass consists of exactly two completed reads.
- R3: If bit 6 of the second read of a pass equals bit 6 of the first read, the poll ends with `ok` high, and no reset write is made.
- R4: If bit 6 differs between the two reads, bit 5 of the second read is 0, and the watchdog has not expired, a new pair of reads starts at once.
- R5: If bit 6 differs and bit 5 of the second read is 1, a recheck pair of reads follows, even when the watchdog limit is reached on that same pass.
- R6: A recheck pair whose bit 6 values match ends with `ok`. A recheck pair whose bit 6 values differ leads to the reset write and then `fail`.
- R7: Every completed pair counts as one pass. When a pass toggles with bit 5 at 0 and the pass count reaches `cfg_max_passes`, the poll fails through the reset write. A setting of 0 behaves as 1.
- R8: The reset write holds `wr_req` high, with `wr_data` equal to `cfg_reset_cmd`, until `wr_ack` is high. It occurs only on the failure paths, and exactly once per failed poll.
- R9: `done` is high for exactly one cycle, in the cycle after the final transfer. `ok` and `fail` are never both high, and they hold their value until the next accepted `start`, which clears both.
- R10: A `start` while `busy` is high has no effect on the read and write sequence or on the result.
- R11: `rd_req` and `wr_req` are never high together, and `busy` is high whenever either of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin polling (taken only when idle) |
| cfg_max_passes | input | PASS_W | Watchdog limit on read pairs (0 treated as 1) |
| cfg_reset_cmd | input | DATA_W | Command byte sent on failure |
| busy | output | 1 | Poll in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Operation completed successfully (held) |
| fail | output | 1 | Operation failed or watchdog expired (held) |
| rd_req | output | 1 | Status read request |
| rd_ack | input | 1 | Read data valid this cycle |
| rd_data | input | DATA_W | Status byte from the flash |
| wr_req | output | 1 | Reset command write request |
| wr_ack | input | 1 | Write accepted this cycle |
| wr_data | output | DATA_W | Reset command byte |

## Verification
The watchdog expiry and the timing-limit flag can both be decided on the same completed pass. This collision is provoked by setting `cfg_max_passes` to 2 and making the second pass toggle with bit 5 set. The cycle-accurate reference model expects a third pair of reads, not the reset write, and the outcome then follows the recheck: one run with a settled recheck and one with a still-toggling recheck. Wait states on both acknowledges and a stray `start` mid-poll are mixed in, so that every output is compared on every clock.

// File: rtl/ftp_pkg.sv
// Package: shared state encoding for the toggle-bit poller.
// Assumes: nothing beyond SystemVerilog enum support.
package ftp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RD_A   = 2'd1,
        ST_RD_B   = 2'd2,
        ST_RST_WR = 2'd3
    } poll_state_t;
endpackage

// File: rtl/ftp_toggle_cmp.sv
// Module: ftp_toggle_cmp
// Stores the toggle bit of the first read of a pair and compares it with
// the toggle bit of the byte currently presented. It also extracts the
// timing-limit flag from that byte.
// Assumes: cap_first is pulsed only in a cycle where data is valid.
module ftp_toggle_cmp #(
    parameter int DATA_W  = 8,
    parameter int TOG_IDX = 6,
    parameter int LIM_IDX = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_first,
    input  logic [DATA_W-1:0] data,
    output logic              toggled,
    output logic              limit_set
);
    logic first_tog_q;

    // Hold the toggle bit taken from the first read of the pair.
    always_ff @(posedge clk) begin
        if (!rst_n)         first_tog_q <= 1'b0;
        else if (cap_first) first_tog_q <= data[TOG_IDX];
    end

    // Compare the presented byte against the stored bit and pick out the flag.
    always_comb begin
        toggled   = first_tog_q ^ data[TOG_IDX];
        limit_set = data[LIM_IDX];
    end
endmodule

// File: rtl/ftp_pass_cnt.sv
// Module: ftp_pass_cnt
// Counts completed read pairs and signals when the pair completing now
// brings the count to the programmed limit. A limit of 0 acts as 1.
// Assumes: clr and inc are never asserted in the same cycle.
module ftp_pass_cnt #(
    parameter int PASS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    input  logic [PASS_W-1:0] max_passes,
    output logic              expired
);
    localparam logic [PASS_W-1:0] CNT_MAX = {PASS_W{1'b1}};
    logic [PASS_W-1:0] cnt_q;
    logic [PASS_W:0]   cnt_next_ext;

    // Saturating count of completed pairs, cleared at each new poll.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (clr)                     cnt_q <= '0;
        else if (inc && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    // Limit test on the count the current pair would produce.
    always_comb begin
        cnt_next_ext = {1'b0, cnt_q} + 1'b1;
        expired      = cnt_next_ext >= {1'b0, max_passes};
    end

    // R7
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> (cnt_q != '0));
endmodule

// File: rtl/ftp_poll_fsm.sv
// Module: ftp_poll_fsm
// Sequences the status reads, decides the outcome of each read pair,
// issues the reset write on failure and holds the result flags.
// Assumes: the bus partner keeps rd_data valid in the cycle rd_ack is high.
module ftp_poll_fsm
    import ftp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rd_ack,
    input  logic wr_ack,
    input  logic toggled,
    input  logic limit_set,
    input  logic expired,
    output logic cap_first,
    output logic cnt_clr,
    output logic cnt_inc,
    output logic rd_req,
    output logic wr_req,
    output logic busy,
    output logic done,
    output logic ok,
    output logic fail
);
    poll_state_t state_q, state_d;
    logic recheck_q, recheck_d;
    logic done_q, done_d;
    logic ok_q, ok_d;
    logic fail_q, fail_d;

    // Next-state and result decisions for the polling algorithm.
    always_comb begin
        state_d   = state_q;
        recheck_d = recheck_q;
        done_d    = 1'b0;
        ok_d      = ok_q;
        fail_d    = fail_q;
        cap_first = 1'b0;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d   = ST_RD_A;
                    recheck_d = 1'b0;
                    ok_d      = 1'b0;
                    fail_d    = 1'b0;
                    cnt_clr   = 1'b1;
                end
            end
            ST_RD_A: begin
                if (rd_ack) begin
                    cap_first = 1'b1;
                    state_d   = ST_RD_B;
                end
            end
            ST_RD_B: begin
                if (rd_ack) begin
                    cnt_inc = 1'b1;
                    if (!toggled) begin
                        state_d = ST_IDLE;
                        ok_d    = 1'b1;
                        done_d  = 1'b1;
                    end else if (recheck_q) begin
                        state_d = ST_RST_WR;
                    end else if (limit_set) begin
                        recheck_d = 1'b1;
                        state_d   = ST_RD_A;
                    end else if (expired) begin
                        state_d = ST_RST_WR;
                    end else begin
                        state_d = ST_RD_A;
                    end
                end
            end
            ST_RST_WR: begin
                if (wr_ack) begin
                    state_d = ST_IDLE;
                    fail_d  = 1'b1;
                    done_d  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            recheck_q <= 1'b0;
            done_q    <= 1'b0;
            ok_q      <= 1'b0;
            fail_q    <= 1'b0;
        end else begin
            state_q   <= state_d;
            recheck_q <= recheck_d;
            done_q    <= done_d;
            ok_q      <= ok_d;
            fail_q    <= fail_d;
        end
    end

    // Bus requests and status outputs decoded from the state.
    always_comb begin
        rd_req = (state_q == ST_RD_A) || (state_q == ST_RD_B);
        wr_req = (state_q == ST_RST_WR);
        busy   = (state_q != ST_IDLE);
        done   = done_q;
        ok     = ok_q;
        fail   = fail_q;
    end

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> rd_req);
    // R8
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> wr_req);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: rtl/flash_toggle_poller.sv
// Module: flash_toggle_poller (top)
// Polls a NOR flash status byte until its toggle bit settles. On an
// unsettled recheck or a watchdog expiry it writes a reset command and
// reports failure.
// Assumes: read and write ports are single-outstanding request/acknowledge.
module flash_toggle_poller #(
    parameter int DATA_W  = 8,
    parameter int TOG_IDX = 6,
    parameter int LIM_IDX = 5,
    parameter int PASS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PASS_W-1:0] cfg_max_passes,
    input  logic [DATA_W-1:0] cfg_reset_cmd,
    output logic              busy,
    output logic              done,
    output logic              ok,
    output logic              fail,
    output logic              rd_req,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_req,
    input  logic              wr_ack,
    output logic [DATA_W-1:0] wr_data
);
    logic cap_first, cnt_clr, cnt_inc;
    logic toggled, limit_set, expired;

    ftp_toggle_cmp #(.DATA_W(DATA_W), .TOG_IDX(TOG_IDX), .LIM_IDX(LIM_IDX)) u_cmp (
        .clk(clk), .rst_n(rst_n), .cap_first(cap_first), .data(rd_data),
        .toggled(toggled), .limit_set(limit_set)
    );

    ftp_pass_cnt #(.PASS_W(PASS_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
        .max_passes(cfg_max_passes), .expired(expired)
    );

    ftp_poll_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_ack(rd_ack), .wr_ack(wr_ack),
        .toggled(toggled), .limit_set(limit_set), .expired(expired),
        .cap_first(cap_first), .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
        .rd_req(rd_req), .wr_req(wr_req), .busy(busy), .done(done),
        .ok(ok), .fail(fail)
    );

    // Command byte presented on the write port.
    always_comb wr_data = cfg_reset_cmd;

    // R11
    bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));
    // R11
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || wr_req) |-> busy);
    // R9
    result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok && fail));
endmodule

// File: tb/test_flash_toggle_poller.sv
module test_flash_toggle_poller;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [15:0] cfg_max_passes = 16'd8;
    logic [7:0] cfg_reset_cmd = 8'hF0;
    logic busy, done, ok, fail, rd_req, wr_req;
    logic rd_ack = 1'b0;
    logic wr_ack = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic [7:0] wr_data;

    flash_toggle_poller i_flash_toggle_poller (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_max_passes(cfg_max_passes),
        .cfg_reset_cmd(cfg_reset_cmd), .busy(busy), .done(done), .ok(ok), .fail(fail),
        .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data), .wr_req(wr_req),
        .wr_ack(wr_ack), .wr_data(wr_data)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit compare_on = 1'b0;

    // bus partner script
    logic [7:0] status_q[$];
    int rd_wait = 0, wr_wait = 0, rd_wcnt = 0, wr_wcnt = 0;
    int n_reads = 0, n_writes = 0;
    logic [7:0] last_wr = 8'h00;

    // reference model state
    int  m_ph = 0;          // 0 idle, 1 first read, 2 second read, 3 reset write
    bit  m_first = 0, m_re = 0, m_done = 0, m_ok = 0, m_fail = 0;
    int  m_cnt = 0;

    task automatic check(input bit cond, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    // behavioural model advanced on each clock from the sampled inputs
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_ph = 0; m_re = 0; m_done = 0; m_ok = 0; m_fail = 0; m_cnt = 0; m_first = 0;
        end else begin
            m_done = 0;
            if (m_ph == 0) begin
                if (start) begin m_ph = 1; m_ok = 0; m_fail = 0; m_re = 0; m_cnt = 0; end
            end else if (m_ph == 1) begin
                if (rd_ack) begin m_first = rd_data[6]; m_ph = 2; end
            end else if (m_ph == 2) begin
                if (rd_ack) begin
                    m_cnt++;
                    if (rd_data[6] == m_first) begin m_ph = 0; m_ok = 1; m_done = 1; end
                    else if (m_re) m_ph = 3;
                    else if (rd_data[5]) begin m_re = 1; m_ph = 1; end
                    else if (m_cnt >= ((cfg_max_passes == 0) ? 1 : int'(cfg_max_passes))) m_ph = 3;
                    else m_ph = 1;
                end
            end else begin
                if (wr_ack) begin m_ph = 0; m_fail = 1; m_done = 1; end
            end
        end
        if (rd_req && rd_ack) n_reads++;
        if (wr_req && wr_ack) begin n_writes++; last_wr = wr_data; end
    end

    // compare every output to the model, then drive the bus partner
    always @(negedge clk) begin
        if (compare_on) begin
            check(busy == (m_ph != 0), "R2", "busy", busy, m_ph != 0);
            check(rd_req == (m_ph == 1 || m_ph == 2), "R4", "rd_req", rd_req, m_ph == 1 || m_ph == 2);
            check(wr_req == (m_ph == 3), "R8", "wr_req", wr_req, m_ph == 3);
            if (wr_req) check(wr_data == cfg_reset_cmd, "R8", "wr_data", wr_data, cfg_reset_cmd);
            check(done == m_done, "R9", "done", done, m_done);
            check(ok == m_ok, "R3", "ok", ok, m_ok);
            check(fail == m_fail, "R6", "fail", fail, m_fail);
            check(!(rd_req && wr_req), "R11", "rd_req&wr_req", rd_req & wr_req, 0);
        end
        rd_ack = 1'b0;
        wr_ack = 1'b0;
        if (rd_req) begin
            if (rd_wcnt >= rd_wait) begin
                rd_ack = 1'b1;
                rd_data = (status_q.size() > 0) ? status_q.pop_front() : 8'h00;
                rd_wcnt = 0;
            end else rd_wcnt++;
        end
        if (wr_req) begin
            if (wr_wcnt >= wr_wait) begin wr_ack = 1'b1; wr_wcnt = 0; end
            else wr_wcnt++;
        end
    end

    task automatic run(input string tag, input int maxp, input logic [7:0] cmd,
                       input int rw, input int ww, input bit stray,
                       input int exp_rd, input int exp_wr, input bit exp_ok);
        int guard;
        cfg_max_passes = 16'(maxp);
        cfg_reset_cmd = cmd;
        rd_wait = rw; wr_wait = ww;
        n_reads = 0; n_writes = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy && rd_req, "R2", "busy/rd_req after start", {busy, rd_req}, 3);
        if (stray) begin
            repeat (2) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 2000) begin @(negedge clk); guard++; end
        check(n_reads == exp_rd, tag, "read count", n_reads, exp_rd);
        check(n_writes == exp_wr, "R8", "write count", n_writes, exp_wr);
        if (exp_wr > 0) check(last_wr == cmd, "R8", "written command", last_wr, cmd);
        check(ok == exp_ok && fail == !exp_ok, tag, "result ok/fail", {ok, fail}, {exp_ok, !exp_ok});
        repeat (3) @(negedge clk);
        check(ok == exp_ok && fail == !exp_ok, "R9", "result held", {ok, fail}, {exp_ok, !exp_ok});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !ok && !fail && !rd_req && !wr_req, "R1", "reset outputs",
              {busy, done, ok, fail, rd_req, wr_req}, 0);
        rst_n = 1'b1;
        compare_on = 1'b1;
        @(negedge clk);
        // R3 settled on first pair
        status_q = {8'h40, 8'h40};
        run("R3", 8, 8'hF0, 0, 0, 0, 2, 0, 1);
        // R4 two toggling passes then settled, wait states, stray start (R10)
        status_q = {8'h40, 8'h00, 8'h00, 8'h40, 8'h00, 8'h00};
        run("R10", 8, 8'hF0, 2, 0, 1, 6, 0, 1);
        // R5 limit flag then settled recheck
        status_q = {8'h00, 8'h60, 8'h20, 8'h20};
        run("R5", 8, 8'hF0, 0, 0, 0, 4, 0, 1);
        // R6 limit flag then still toggling: reset write with custom command
        status_q = {8'h00, 8'h60, 8'h20, 8'h60};
        run("R6", 8, 8'hA5, 1, 3, 0, 4, 1, 0);
        // R7 watchdog at three passes
        status_q = {8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00};
        run("R7", 3, 8'h3C, 0, 1, 0, 6, 1, 0);
        // R7 limit 0 acts as 1
        status_q = {8'h00, 8'h40};
        run("R7", 0, 8'hF0, 0, 0, 0, 2, 1, 0);
        // R5 watchdog and limit flag on the same pass, settled recheck
        status_q = {8'h00, 8'h40, 8'h00, 8'h60, 8'h20, 8'h20};
        run("R5", 2, 8'hF0, 0, 0, 0, 6, 0, 1);
        // R6 same collision, recheck still toggling
        status_q = {8'h00, 8'h40, 8'h00, 8'h60, 8'h20, 8'h60};
        run("R6", 2, 8'h5A, 0, 2, 0, 6, 1, 0);
        // R9 a new start clears the held result
        status_q = {8'h40, 8'h00, 8'h00, 8'h00};
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(!ok && !fail, "R9", "flags cleared by start", {ok, fail}, 0);
        repeat (20) @(negedge clk);
        // R1 reset mid-run
        status_q = {8'h40, 8'h00};
        cfg_max_passes = 16'd50;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check(!busy && !rd_req && !wr_req && !ok && !fail && !done, "R1", "reset mid-run",
              {busy, rd_req, wr_req, ok, fail, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        errors++;
        $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule